// File: doc/BRIEF.md
# Vertex Shader Program and Operand Descriptor Loader

This block is the register-write front end that fills a programmable vertex shader's stores before execution. A simple write port carries a register address, a 32-bit value and a byte-enable mask. Two groups of registers feed two auto-incrementing upload paths.

The operand descriptor path has one pointer register and eight aliased data addresses. Any data address stores one word in the 128-entry descriptor table and advances the pointer. The program path has its own pointer register and its own eight aliased data addresses. It writes into a 512-word staging buffer.

The execution unit never sees the staging buffer. A nonzero write to the transfer-end register starts a copy of the whole staging buffer into active program memory, one word per cycle. While that copy runs, a busy flag is high and the program path refuses all writes. The execution unit reads descriptors and active program words through two registered read ports.

Top module: `shaderLoadFront`

## Requirements
- R1: After reset, every descriptor entry and every active program word reads as zero, and `commitBusy` is low.
- R2: A full-mask write to the descriptor pointer register (address 0x2D5) loads the descriptor write pointer with bits [6:0] of the written value.
- R3: A full-mask write to any address from 0x2D6 to 0x2DD stores the 32-bit value at the descriptor pointer and then increments the pointer. The increment wraps from 127 to 0.
- R4: A full-mask write to the program pointer register (address 0x2CB) loads the program write pointer with bits [10:2] of the written value, that is the byte offset shifted right by 2 and masked to 9 bits.
- R5: A full-mask write to any address from 0x2CC to 0x2D3 stores the value in the staging buffer at the program pointer and then increments the pointer. The increment wraps from 511 to 0.
- R6: Staged program words do not appear on the program read port until a commit has completed.
- R7: A full-mask write of a nonzero value to the transfer-end register (address 0x2BF) raises `commitBusy` for exactly 512 cycles. During that time every staging word is copied to the same index of active program memory. Active words that are not covered by the copy keep the values they had.
- R8: A write of zero to the transfer-end register starts no commit and changes no memory.
- R9: While `commitBusy` is high, writes to the program pointer, program data and transfer-end registers are ignored. Descriptor writes are still accepted.
- R10: A write whose byte-enable mask is not 4'b1111 has no effect on any pointer, memory or commit.
- R11: Each read port returns the word at the address presented one cycle earlier. The output holds its previous value until the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 10 | Register address of the write |
| wrData | input | 32 | Write value |
| wrBe | input | 4 | Byte enables; a write takes effect only when all are set |
| descRdAddr | input | 7 | Descriptor table read index |
| descRdData | output | 32 | Descriptor word, registered |
| progRdAddr | input | 9 | Active program memory read index |
| progRdData | output | 32 | Active program word, registered |
| commitBusy | output | 1 | High while the staging-to-active copy runs |

## Verification
A write sampled at one rising edge updates its memory and pointer at that same edge. A read address therefore sees the new word on the data output one edge later. The transfer-end write raises `commitBusy` at the edge that samples it, and the flag falls 512 edges later.

The bench drives every input on a falling edge. Each read pushes its expected word into a scoreboard queue. A monitor pops that entry just after the following rising edge, so every comparison falls exactly one register stage after its address was driven. The busy flag is counted on falling edges from the first falling edge after the commit write. Program contents are read only after the flag has dropped.

// File: rtl/shaderLoadPkg.sv
package shaderLoadPkg;

  // Strobes from the register decoder to the storage datapath
  typedef struct packed {
    logic descIdxLd;  // load descriptor write pointer
    logic descWr;     // store a descriptor word, advance pointer
    logic codeIdxLd;  // load staging write pointer
    logic codeWr;     // store a staging word, advance pointer
    logic copyEn;     // copy one staging word to active memory
  } loadStrobes_t;

endpackage

// File: rtl/shaderLoadCtrl.sv
module shaderLoadCtrl
  import shaderLoadPkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int DATA_W      = 32,
  parameter int BE_W        = DATA_W / 8,
  parameter int PROG_DEPTH  = 512,
  parameter int GROUP_SIZE  = 8,
  parameter int DESC_IDX_A  = 'h2D5,
  parameter int DESC_DATA_A = 'h2D6,
  parameter int CODE_IDX_A  = 'h2CB,
  parameter int CODE_DATA_A = 'h2CC,
  parameter int CODE_END_A  = 'h2BF,
  localparam int PROG_AW    = $clog2(PROG_DEPTH)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [BE_W-1:0]    wrBe,
  output loadStrobes_t       stb,
  output logic [PROG_AW-1:0] copyIdx,
  output logic               busy
);

  localparam logic [ADDR_W-1:0]  descIdxV  = ADDR_W'(DESC_IDX_A);
  localparam logic [ADDR_W-1:0]  descBaseV = ADDR_W'(DESC_DATA_A);
  localparam logic [ADDR_W-1:0]  codeIdxV  = ADDR_W'(CODE_IDX_A);
  localparam logic [ADDR_W-1:0]  codeBaseV = ADDR_W'(CODE_DATA_A);
  localparam logic [ADDR_W-1:0]  codeEndV  = ADDR_W'(CODE_END_A);
  localparam logic [ADDR_W-1:0]  groupV    = ADDR_W'(GROUP_SIZE);
  localparam logic [PROG_AW-1:0] lastIdx   = PROG_AW'(PROG_DEPTH - 1);

  logic              fullWr;
  logic [ADDR_W-1:0] descOff;
  logic [ADDR_W-1:0] codeOff;
  logic              startCopy;

  always_comb begin
    fullWr    = wrEn && (wrBe == {BE_W{1'b1}});
    descOff   = wrAddr - descBaseV;
    codeOff   = wrAddr - codeBaseV;
    startCopy = fullWr && !busy && (wrAddr == codeEndV) && (wrData != '0);

    stb.descIdxLd = fullWr && (wrAddr == descIdxV);
    stb.descWr    = fullWr && (descOff < groupV);
    stb.codeIdxLd = fullWr && !busy && (wrAddr == codeIdxV);
    stb.codeWr    = fullWr && !busy && (codeOff < groupV);
    stb.copyEn    = busy;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      copyIdx <= '0;
    end else if (startCopy) begin
      busy    <= 1'b1;
      copyIdx <= '0;
    end else if (busy) begin
      copyIdx <= copyIdx + 1'b1;
      if (copyIdx == lastIdx) busy <= 1'b0;
    end
  end

  // R7: an accepted nonzero transfer-end write starts the copy
  assert_commit_start_R7: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrBe == {BE_W{1'b1}} && wrAddr == codeEndV && wrData != '0 && !busy) |=> busy);

  // R7: the copy ends right after the last index
  assert_copy_end_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busy && copyIdx == lastIdx) |=> !busy);

  // R8: a zero transfer-end write while idle leaves the block idle
  assert_zero_noop_R8: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == codeEndV && wrData == '0 && !busy) |=> !busy);

  // R10: a partial mask produces no strobe of the write paths
  assert_partial_mask_R10: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrBe != {BE_W{1'b1}}) |-> !(stb.descIdxLd || stb.descWr || stb.codeIdxLd || stb.codeWr));

endmodule

// File: rtl/shaderLoadData.sv
module shaderLoadData
  import shaderLoadPkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int DESC_DEPTH = 128,
  parameter int PROG_DEPTH = 512,
  localparam int DESC_AW   = $clog2(DESC_DEPTH),
  localparam int PROG_AW   = $clog2(PROG_DEPTH)
) (
  input  logic               clk,
  input  logic               rstN,
  input  loadStrobes_t       stb,
  input  logic [PROG_AW-1:0] copyIdx,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [DESC_AW-1:0] descRdAddr,
  output logic [DATA_W-1:0]  descRdData,
  input  logic [PROG_AW-1:0] progRdAddr,
  output logic [DATA_W-1:0]  progRdData
);

  logic [DATA_W-1:0]  descMem  [DESC_DEPTH];
  logic [DATA_W-1:0]  stageMem [PROG_DEPTH];
  logic [DATA_W-1:0]  progMem  [PROG_DEPTH];
  logic [DESC_AW-1:0] descPtr;
  logic [PROG_AW-1:0] codePtr;

  // Descriptor table and its pointer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      descPtr    <= '0;
      descRdData <= '0;
      for (int i = 0; i < DESC_DEPTH; i++) descMem[i] <= '0;
    end else begin
      descRdData <= descMem[descRdAddr];
      if (stb.descIdxLd) begin
        descPtr <= wrData[DESC_AW-1:0];
      end else if (stb.descWr) begin
        descMem[descPtr] <= wrData;
        descPtr          <= descPtr + 1'b1;
      end
    end
  end

  // Staging buffer and its pointer (byte offset -> word index)
  always_ff @(posedge clk) begin
    if (!rstN) begin
      codePtr <= '0;
      for (int i = 0; i < PROG_DEPTH; i++) stageMem[i] <= '0;
    end else if (stb.codeIdxLd) begin
      codePtr <= wrData[PROG_AW+1:2];
    end else if (stb.codeWr) begin
      stageMem[codePtr] <= wrData;
      codePtr           <= codePtr + 1'b1;
    end
  end

  // Active program memory, filled only by the copy
  always_ff @(posedge clk) begin
    if (!rstN) begin
      progRdData <= '0;
      for (int i = 0; i < PROG_DEPTH; i++) progMem[i] <= '0;
    end else begin
      progRdData <= progMem[progRdAddr];
      if (stb.copyEn) progMem[copyIdx] <= stageMem[copyIdx];
    end
  end

  // R3: each descriptor store advances the pointer by one
  assert_desc_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    stb.descWr && !stb.descIdxLd |=> descPtr == $past(descPtr) + 1'b1);

  // R9: the staging pointer does not move while the copy runs
  assert_ptr_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    stb.copyEn |=> $stable(codePtr));

  // R7: each copy cycle moves the indexed staging word into active memory
  assert_copy_word_R7: assert property (@(posedge clk) disable iff (!rstN)
    stb.copyEn |=> progMem[$past(copyIdx)] == $past(stageMem[copyIdx]));

endmodule

// File: rtl/shaderLoadFront.sv
module shaderLoadFront
  import shaderLoadPkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int DATA_W      = 32,
  parameter int DESC_DEPTH  = 128,
  parameter int PROG_DEPTH  = 512,
  parameter int GROUP_SIZE  = 8,
  parameter int DESC_IDX_A  = 'h2D5,
  parameter int DESC_DATA_A = 'h2D6,
  parameter int CODE_IDX_A  = 'h2CB,
  parameter int CODE_DATA_A = 'h2CC,
  parameter int CODE_END_A  = 'h2BF,
  localparam int BE_W       = DATA_W / 8,
  localparam int DESC_AW    = $clog2(DESC_DEPTH),
  localparam int PROG_AW    = $clog2(PROG_DEPTH)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [BE_W-1:0]    wrBe,
  input  logic [DESC_AW-1:0] descRdAddr,
  output logic [DATA_W-1:0]  descRdData,
  input  logic [PROG_AW-1:0] progRdAddr,
  output logic [DATA_W-1:0]  progRdData,
  output logic               commitBusy
);

  loadStrobes_t       stb;
  logic [PROG_AW-1:0] copyIdx;

  shaderLoadCtrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BE_W(BE_W), .PROG_DEPTH(PROG_DEPTH),
    .GROUP_SIZE(GROUP_SIZE), .DESC_IDX_A(DESC_IDX_A), .DESC_DATA_A(DESC_DATA_A),
    .CODE_IDX_A(CODE_IDX_A), .CODE_DATA_A(CODE_DATA_A), .CODE_END_A(CODE_END_A)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .wrBe(wrBe), .stb(stb), .copyIdx(copyIdx), .busy(commitBusy)
  );

  shaderLoadData #(
    .DATA_W(DATA_W), .DESC_DEPTH(DESC_DEPTH), .PROG_DEPTH(PROG_DEPTH)
  ) i_data (
    .clk(clk), .rstN(rstN), .stb(stb), .copyIdx(copyIdx), .wrData(wrData),
    .descRdAddr(descRdAddr), .descRdData(descRdData),
    .progRdAddr(progRdAddr), .progRdData(progRdData)
  );

endmodule

// File: tb/test_shaderLoadFront.sv
module test_shaderLoadFront;

  localparam logic [9:0] DIDX  = 10'h2D5;
  localparam logic [9:0] DDAT  = 10'h2D6;
  localparam logic [9:0] CIDX  = 10'h2CB;
  localparam logic [9:0] CDAT  = 10'h2CC;
  localparam logic [9:0] CEND  = 10'h2BF;
  localparam logic [3:0] FULL  = 4'hF;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [9:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [3:0]  wrBe = '0;
  logic [6:0]  descRdAddr = '0;
  logic [31:0] descRdData;
  logic [8:0]  progRdAddr = '0;
  logic [31:0] progRdData;
  logic        commitBusy;

  int compared = 0;
  int mismatched = 0;

  // scoreboard queues
  bit          qIsProg[$];
  logic [31:0] qExp[$];
  string       qTag[$];

  always #5 clk = ~clk;

  shaderLoadFront i_shaderLoadFront (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .wrBe(wrBe), .descRdAddr(descRdAddr), .descRdData(descRdData),
    .progRdAddr(progRdAddr), .progRdData(progRdData), .commitBusy(commitBusy)
  );

  task automatic checkVal(input logic [31:0] act, input logic [31:0] exp, input string tag);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [9:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d; wrBe = be;
    @(negedge clk);
    wrEn = 1'b0; wrBe = '0;
  endtask

  task automatic readDesc(input logic [6:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    descRdAddr = a;
    qIsProg.push_back(1'b0); qExp.push_back(exp); qTag.push_back(tag);
  endtask

  task automatic readProg(input logic [8:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    progRdAddr = a;
    qIsProg.push_back(1'b1); qExp.push_back(exp); qTag.push_back(tag);
  endtask

  task automatic waitIdle();
    while (commitBusy) @(negedge clk);
  endtask

  // monitor: data is due one rising edge after the address was driven
  always @(posedge clk) begin
    #2;
    while (qExp.size() > 0) begin
      bit          isP;
      logic [31:0] e;
      string       t;
      isP = qIsProg.pop_front();
      e   = qExp.pop_front();
      t   = qTag.pop_front();
      checkVal(isP ? progRdData : descRdData, e, t);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int busyCnt;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    checkVal({31'b0, commitBusy}, 32'h0, "R1 busy after reset");
    readDesc(7'd0, 32'h0, "R1 desc[0]");
    readDesc(7'd127, 32'h0, "R1 desc[127]");
    readProg(9'd0, 32'h0, "R1 prog[0]");
    readProg(9'd511, 32'h0, "R1 prog[511]");

    // R2 pointer load (low 7 bits of 0x17E = 126), R3 aliasing and wrap
    regWrite(DIDX, 32'h0000_017E, FULL);
    regWrite(DDAT, 32'hAAAA_0001, FULL);
    regWrite(DDAT + 10'd7, 32'hBBBB_0002, FULL);
    regWrite(DDAT + 10'd3, 32'hCCCC_0003, FULL);
    readDesc(7'd126, 32'hAAAA_0001, "R2 desc[126]");
    readDesc(7'd127, 32'hBBBB_0002, "R3 desc[127]");
    readDesc(7'd0, 32'hCCCC_0003, "R3 wrap desc[0]");

    // R10 partial masks ignored (pointer stays at 1)
    regWrite(DDAT + 10'd1, 32'hDDDD_0004, 4'h7);
    regWrite(DIDX, 32'h0000_0040, 4'hE);
    regWrite(DDAT + 10'd1, 32'hEEEE_0005, FULL);
    readDesc(7'd1, 32'hEEEE_0005, "R10 desc[1]");
    readDesc(7'd2, 32'h0, "R10 desc[2]");
    readDesc(7'd64, 32'h0, "R10 desc[64]");

    // R4 byte offset 0x7F8 -> 510, R5 wrap, R4 mask 0x804 -> 1
    regWrite(CIDX, 32'h0000_07F8, FULL);
    regWrite(CDAT, 32'h1000_0510, FULL);
    regWrite(CDAT + 10'd7, 32'h1000_0511, FULL);
    regWrite(CDAT + 10'd3, 32'h1000_0000, FULL);
    regWrite(CIDX, 32'h0000_0804, FULL);
    regWrite(CDAT + 10'd1, 32'h1000_0001, FULL);
    readProg(9'd510, 32'h0, "R6 prog[510] before commit");
    readProg(9'd0, 32'h0, "R6 prog[0] before commit");

    // R8 zero end write; R10 partial end write
    regWrite(CEND, 32'h0, FULL);
    checkVal({31'b0, commitBusy}, 32'h0, "R8 busy after zero end");
    regWrite(CEND, 32'h1, 4'hB);
    checkVal({31'b0, commitBusy}, 32'h0, "R10 busy after partial end");
    readProg(9'd510, 32'h0, "R8 prog[510] unchanged");

    // R7 commit and busy length
    regWrite(CEND, 32'h5, FULL);
    busyCnt = 0;
    while (commitBusy) begin
      busyCnt++;
      @(negedge clk);
    end
    checkVal(busyCnt, 32'd512, "R7 busy cycles");
    readProg(9'd510, 32'h1000_0510, "R7 R4 prog[510]");
    readProg(9'd511, 32'h1000_0511, "R5 prog[511]");
    readProg(9'd0, 32'h1000_0000, "R5 wrap prog[0]");
    readProg(9'd1, 32'h1000_0001, "R4 mask prog[1]");
    readProg(9'd2, 32'h0, "R7 prog[2]");

    // R9 program writes during copy ignored; descriptor writes accepted
    regWrite(CEND, 32'h1, FULL);
    regWrite(CIDX, 32'h0000_0040, FULL);
    regWrite(CDAT, 32'h9999_0016, FULL);
    regWrite(DDAT, 32'h7777_0002, FULL);
    regWrite(CEND, 32'h1, FULL);
    waitIdle();
    @(negedge clk);
    checkVal({31'b0, commitBusy}, 32'h0, "R9 no retrigger");
    regWrite(CDAT, 32'h2222_0002, FULL);
    regWrite(CEND, 32'h1, FULL);
    waitIdle();
    readProg(9'd16, 32'h0, "R9 prog[16] untouched");
    readProg(9'd2, 32'h2222_0002, "R9 pointer kept, prog[2]");
    readProg(9'd510, 32'h1000_0510, "R7 prog[510] kept");
    readDesc(7'd2, 32'h7777_0002, "R9 desc write during copy");

    // R11 registered read: output holds until the next edge
    readDesc(7'd0, 32'hCCCC_0003, "R11 desc[0]");
    @(negedge clk);
    @(negedge clk);
    descRdAddr = 7'd126;
    #1;
    checkVal(descRdData, 32'hCCCC_0003, "R11 holds before edge");
    @(posedge clk);
    #2;
    checkVal(descRdData, 32'hAAAA_0001, "R11 updates after edge");

    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule